// File: doc/BRIEF.md
# Rate-Limited State-of-Charge Correction Blender

This block produces the state-of-charge figure that a battery gauge reports. It forms a target by mixing two estimates: one from the open-circuit-voltage table and one from the charge integrator. A weight α (unsigned Q0.8) sets the mix. During normal running the reported value follows the target with no limit.

When the surrounding state logic signals a wake-up or a power-path switch, the block enters a correction phase. In that phase the reported value moves toward the target under two limits: a cap on any single jump and a slew budget that refills once per second. While a cell-balancing window is open, movement is frozen. Every step applied during a correction emits an event carrying the reason code that was latched at entry and a seconds timestamp. The block returns to free tracking once the reported value has reached the target.

Values are in 0.01 % units (10000 = full). α is generated elsewhere and enters the block as an input.

Top module: `soc_corr_blender`

## Requirements
- R1: The target equals (α·ocv + (256−α)·cc + 128) >> 8, with α an unsigned Q0.8 fraction, rounded to nearest. The target is registered once.
- R2: Outside a correction phase, `soc_o` takes the target on the clock after the target register, with no limit on the jump, and `limiting_o` is 0.
- R3: A `corr_req_i` pulse while tracking starts a correction phase from the next clock. No single change of `soc_o` during the phase exceeds 300 counts (3 %). The first step may use up to that full 300.
- R4: During a correction, the step budget grows only on `tick_i`, by 100 counts per tick (1 %/s), and is capped at 300. Between ticks, once the budget is spent, `soc_o` does not move.
- R5: Each cycle in which a correction moves `soc_o` raises `evt_valid_o` for one cycle, with that same change. `evt_reason_o` carries the 3-bit reason latched at entry. `evt_time_o` carries the number of ticks seen since reset.
- R6: While `balance_i` is 1 during a correction, `soc_o` holds its value. Budget keeps accruing up to the 300 cap.
- R7: When `soc_o` equals the target during a correction, `limiting_o` falls on the next clock and free tracking (R2) resumes.
- R8: After reset, `soc_o` is 0, `limiting_o` is 0, `evt_valid_o` is 0 and the timestamp is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soc_ocv_i | input | 14 | Voltage-table SoC estimate, 0.01 % units |
| soc_cc_i | input | 14 | Charge-integrator SoC estimate, 0.01 % units |
| alpha_i | input | 8 | Weight of the voltage estimate, Q0.8 |
| corr_req_i | input | 1 | One-cycle pulse: wake or path-switch occurred |
| reason_i | input | 3 | Reason code sampled with `corr_req_i` |
| balance_i | input | 1 | Cell-balancing window open |
| tick_i | input | 1 | One-cycle 1 Hz strobe |
| soc_o | output | 14 | Reported SoC |
| limiting_o | output | 1 | Correction phase active |
| evt_valid_o | output | 1 | A correction step was applied |
| evt_reason_o | output | 3 | Reason code of the active correction |
| evt_time_o | output | 32 | Tick count when the step was applied |

## Verification
Several checks run on every cycle. No step within a correction exceeds the single-jump cap. The budget never grows without a tick and never exceeds its cap. A balancing window holds the value still. Events occur only inside a correction phase, and the flag drops once the target is met.

Other behaviour is shown only by the bench's scenarios: the exact rounding of the blend, the step sequence of 300 followed by 100 per tick, the release of accrued budget after balancing, and the reason and timestamp values attached to each event.

// File: rtl/soc_corr_pkg.sv
package soc_corr_pkg;
  typedef enum logic {
    S_TRACK = 1'b0,
    S_CORR  = 1'b1
  } corr_state_e;
endpackage

// File: rtl/soc_blend_target.sv
module soc_blend_target #(
  parameter int SOC_W   = 14,
  parameter int ALPHA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SOC_W-1:0]   ocv_i,
  input  logic [SOC_W-1:0]   cc_i,
  input  logic [ALPHA_W-1:0] alpha_i,
  output logic [SOC_W-1:0]   tgt_o
);
  localparam int PROD_W = SOC_W + ALPHA_W + 2;
  localparam logic [PROD_W-1:0] ONE  = PROD_W'(1) << ALPHA_W;
  localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (ALPHA_W - 1);

  logic [PROD_W-1:0] w_ocv, w_cc, acc;
  logic [SOC_W-1:0]  tgt_d, tgt_q;

  always_comb begin
    w_ocv = PROD_W'(alpha_i) * PROD_W'(ocv_i);
    w_cc  = (ONE - PROD_W'(alpha_i)) * PROD_W'(cc_i);
    acc   = w_ocv + w_cc + HALF;
    tgt_d = SOC_W'(acc >> ALPHA_W);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_q <= '0;
    else        tgt_q <= tgt_d;
  end

  assign tgt_o = tgt_q;
endmodule

// File: rtl/soc_step_limiter.sv
module soc_step_limiter #(
  parameter int SOC_W         = 14,
  parameter int STEP_MAX      = 300,
  parameter int RATE_PER_TICK = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             active_i,
  input  logic             freeze_i,
  input  logic             tick_i,
  input  logic [SOC_W-1:0] cur_i,
  input  logic [SOC_W-1:0] tgt_i,
  output logic [SOC_W-1:0] nxt_o,
  output logic             step_en_o,
  output logic             done_o
);
  localparam int CRED_W = $clog2(STEP_MAX + RATE_PER_TICK + 1);
  localparam logic [CRED_W-1:0] CAP  = CRED_W'(STEP_MAX);
  localparam logic [CRED_W-1:0] RATE = CRED_W'(RATE_PER_TICK);

  logic [CRED_W-1:0] credit_q, credit_d, spent, sum;
  logic [SOC_W-1:0]  mag, amt;
  logic              up;

  always_comb begin
    up    = tgt_i > cur_i;
    mag   = up ? (tgt_i - cur_i) : (cur_i - tgt_i);
    amt   = (mag < SOC_W'(credit_q)) ? mag : SOC_W'(credit_q);
    step_en_o = active_i && !freeze_i && (amt != '0);
    nxt_o = up ? (cur_i + amt) : (cur_i - amt);
    done_o = (mag == '0);
    spent = step_en_o ? CRED_W'(amt) : '0;
    sum   = credit_q - spent + (tick_i ? RATE : '0);
    if (start_i)       credit_d = CAP;
    else if (sum > CAP) credit_d = CAP;
    else               credit_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) credit_q <= '0;
    else        credit_q <= credit_d;
  end

  p_credit_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    credit_q <= CAP);

  p_no_gain_without_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !start_i) |=> (credit_q <= $past(credit_q)));
endmodule

// File: rtl/soc_corr_blender.sv
module soc_corr_blender #(
  parameter int SOC_W         = 14,
  parameter int ALPHA_W       = 8,
  parameter int REASON_W      = 3,
  parameter int TS_W          = 32,
  parameter int STEP_MAX      = 300,
  parameter int RATE_PER_TICK = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SOC_W-1:0]    soc_ocv_i,
  input  logic [SOC_W-1:0]    soc_cc_i,
  input  logic [ALPHA_W-1:0]  alpha_i,
  input  logic                corr_req_i,
  input  logic [REASON_W-1:0] reason_i,
  input  logic                balance_i,
  input  logic                tick_i,
  output logic [SOC_W-1:0]    soc_o,
  output logic                limiting_o,
  output logic                evt_valid_o,
  output logic [REASON_W-1:0] evt_reason_o,
  output logic [TS_W-1:0]     evt_time_o
);
  import soc_corr_pkg::*;

  corr_state_e         state_q, state_d;
  logic [SOC_W-1:0]    rep_q, rep_d, tgt, nxt;
  logic [REASON_W-1:0] reason_q, reason_d;
  logic [TS_W-1:0]     ts_q;
  logic                step_en, done, start;
  logic                evt_q;
  logic [REASON_W-1:0] evt_reason_q;
  logic [TS_W-1:0]     evt_time_q;

  soc_blend_target #(.SOC_W(SOC_W), .ALPHA_W(ALPHA_W)) blend_i (
    .clk(clk), .rst_n(rst_n), .ocv_i(soc_ocv_i), .cc_i(soc_cc_i),
    .alpha_i(alpha_i), .tgt_o(tgt)
  );

  assign start = (state_q == S_TRACK) && corr_req_i;

  soc_step_limiter #(.SOC_W(SOC_W), .STEP_MAX(STEP_MAX),
                     .RATE_PER_TICK(RATE_PER_TICK)) lim_i (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .active_i(state_q == S_CORR), .freeze_i(balance_i), .tick_i(tick_i),
    .cur_i(rep_q), .tgt_i(tgt), .nxt_o(nxt), .step_en_o(step_en),
    .done_o(done)
  );

  always_comb begin
    state_d  = state_q;
    rep_d    = rep_q;
    reason_d = reason_q;
    unique case (state_q)
      S_TRACK: begin
        if (corr_req_i) begin
          state_d  = S_CORR;
          reason_d = reason_i;
        end else begin
          rep_d = tgt;
        end
      end
      S_CORR: begin
        if (step_en) rep_d = nxt;
        if (done)    state_d = S_TRACK;
      end
      default: state_d = S_TRACK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_TRACK;
      rep_q        <= '0;
      reason_q     <= '0;
      ts_q         <= '0;
      evt_q        <= 1'b0;
      evt_reason_q <= '0;
      evt_time_q   <= '0;
    end else begin
      state_q  <= state_d;
      rep_q    <= rep_d;
      reason_q <= reason_d;
      if (tick_i) ts_q <= ts_q + 1'b1;
      evt_q <= step_en;
      if (step_en) begin
        evt_reason_q <= reason_q;
        evt_time_q   <= ts_q + (tick_i ? 1'b1 : 1'b0);
      end
    end
  end

  assign soc_o        = rep_q;
  assign limiting_o   = (state_q == S_CORR);
  assign evt_valid_o  = evt_q;
  assign evt_reason_o = evt_reason_q;
  assign evt_time_o   = evt_time_q;

  function automatic logic [SOC_W-1:0] absd(input logic [SOC_W-1:0] a,
                                            input logic [SOC_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  p_step_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CORR) |=> (absd(rep_q, $past(rep_q)) <= SOC_W'(STEP_MAX)));

  p_balance_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CORR && balance_i) |=> $stable(rep_q));

  p_evt_in_corr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o |-> limiting_o);

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_CORR && rep_q == tgt) |=> !limiting_o);
endmodule

// File: tb/soc_corr_blender_tb_top.sv
module soc_corr_blender_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] ocv, cc;
  logic [7:0]  alpha;
  logic        corr_req, balance, tick;
  logic [2:0]  reason;
  logic [13:0] soc;
  logic        limiting, evt_valid;
  logic [2:0]  evt_reason;
  logic [31:0] evt_time;

  int checks = 0;
  int failures = 0;
  int ticks_sent = 0;
  int evt_cnt = 0;
  int exp_reason = 0;

  always #2 clk = ~clk;

  soc_corr_blender dut_i (
    .clk(clk), .rst_n(rst_n), .soc_ocv_i(ocv), .soc_cc_i(cc),
    .alpha_i(alpha), .corr_req_i(corr_req), .reason_i(reason),
    .balance_i(balance), .tick_i(tick), .soc_o(soc),
    .limiting_o(limiting), .evt_valid_o(evt_valid),
    .evt_reason_o(evt_reason), .evt_time_o(evt_time)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && evt_valid) begin
      evt_cnt++;
      chk(int'(evt_reason) == exp_reason, "R5 reason", int'(evt_reason), exp_reason);
      chk(int'(evt_time) == ticks_sent, "R5 timestamp", int'(evt_time), ticks_sent);
    end
  end

  task automatic do_tick();
    tick = 1'b1; ticks_sent++;
    cyc(1);
    tick = 1'b0;
    cyc(4);
  endtask

  task automatic t_reset();
    chk(soc == 14'd0, "R8 soc", int'(soc), 0);
    chk(limiting == 1'b0, "R8 limiting", int'(limiting), 0);
    chk(evt_valid == 1'b0, "R8 evt", int'(evt_valid), 0);
  endtask

  task automatic t_track();
    alpha = 8'd0; cc = 14'd5000; ocv = 14'd0; cyc(3);
    chk(soc == 14'd5000, "R2 follow cc", int'(soc), 5000);
    alpha = 8'd128; ocv = 14'd6000; cyc(3);
    chk(soc == 14'd5500, "R1 half blend", int'(soc), 5500);
    alpha = 8'd1; ocv = 14'd129; cc = 14'd0; cyc(3);
    chk(soc == 14'd1, "R1 round up", int'(soc), 1);
    ocv = 14'd127; cyc(3);
    chk(soc == 14'd0, "R1 round down", int'(soc), 0);
    alpha = 8'd0; cc = 14'd5000; cyc(3);
    chk(soc == 14'd5000, "R2 unlimited jump", int'(soc), 5000);
    chk(limiting == 1'b0, "R2 flag low", int'(limiting), 0);
  endtask

  task automatic t_correct_up();
    int e0;
    e0 = evt_cnt;
    exp_reason = 2;
    cc = 14'd6000; reason = 3'd2; corr_req = 1'b1;
    cyc(1);
    corr_req = 1'b0;
    cyc(3);
    chk(soc == 14'd5300, "R3 first step", int'(soc), 5300);
    chk(limiting == 1'b1, "R3 flag", int'(limiting), 1);
    cyc(10);
    chk(soc == 14'd5300, "R4 hold between ticks", int'(soc), 5300);
    for (int k = 1; k <= 7; k++) begin
      do_tick();
      chk(int'(soc) == 5300 + 100 * k, "R4 per tick", int'(soc), 5300 + 100 * k);
    end
    cyc(3);
    chk(limiting == 1'b0, "R7 flag cleared", int'(limiting), 1'b0);
    chk(evt_cnt - e0 == 8, "R5 event count", evt_cnt - e0, 8);
  endtask

  task automatic t_balance_down();
    int e0;
    e0 = evt_cnt;
    exp_reason = 5;
    balance = 1'b1; cc = 14'd4000; reason = 3'd5; corr_req = 1'b1;
    cyc(1);
    corr_req = 1'b0;
    cyc(3);
    chk(soc == 14'd6000, "R6 frozen", int'(soc), 6000);
    for (int k = 0; k < 4; k++) do_tick();
    chk(soc == 14'd6000, "R6 frozen over ticks", int'(soc), 6000);
    chk(evt_cnt == e0, "R6 no events", evt_cnt - e0, 0);
    balance = 1'b0;
    cyc(3);
    chk(soc == 14'd5700, "R3 capped after freeze", int'(soc), 5700);
    for (int k = 1; k <= 17; k++) do_tick();
    chk(soc == 14'd4000, "R4 converged", int'(soc), 4000);
    cyc(3);
    chk(limiting == 1'b0, "R7 flag cleared down", int'(limiting), 0);
    cc = 14'd4100; cyc(3);
    chk(soc == 14'd4100, "R7 tracking resumed", int'(soc), 4100);
  endtask

  initial begin
    rst_n = 1'b0; ocv = '0; cc = '0; alpha = '0; corr_req = 1'b0;
    balance = 1'b0; tick = 1'b0; reason = '0;
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_track();
    t_correct_up();
    t_balance_down();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule